// File: doc/BRIEF.md
# Neighbor-Gradient Table Shader

This block is a streaming shading stage. It sits behind a projection stage and receives a raster of projected pixels, one per accepted cycle. Each pixel carries a depth and a color, plus markers for the first pixel of a frame and the last pixel of a line.

The block holds the most recent lines in three rotating line-buffer memories. When a pixel arrives, the pixel directly above it becomes the center of a finished window. That center has its left and right neighbors on its own line, the pixel above it in the older line, and the arriving pixel below it. The block takes the horizontal and vertical depth differences and clamps each to a small signed field. The two fields together index a gradient table that is loaded beforehand. The table returns an intensity factor, which scales the center color.

Output runs one line behind the input, plus two register stages. After the last line of a frame, the block emits that line on its own, W consecutive cycles long.

A small write port loads the table. Frame size (W pixels by H lines, H ≥ 2), depth width, color width and gradient field width are parameters.

Top module: `grad_shader`

## Requirements
- R1: After reset, out_valid is low until pixels arrive; no output appears without input.
- R2: The gradients are defined as gx = right depth − left depth and gy = below depth − above depth. Each is clamped to the signed range [−4, 3] (3-bit two's complement). The table index is {gx[2:0], gy[2:0]}, with gx in index bits 5:3 and gy in bits 2:0.
- R3: The shaded output color is (center color × table factor) >> 8.
- R4: At a frame border, a missing neighbor takes the center pixel's depth. This applies to left at column 0, right at column W−1, above on line 0 and below on line H−1.
- R5: Output pixel (r, c) for r < H−1 appears two cycles after input pixel (r+1, c) is presented. Line H−1 follows as W back-to-back pixels. Its column c appears c+3 cycles after the last input pixel.
- R6: out_sof marks output pixel (0, 0) and out_eol marks every output pixel in column W−1.
- R7: A cycle with tab_we high writes tab_data at tab_addr. Lookups made after the write use the new value.
- R8: An accepted pixel with in_sof high starts a new frame at line 0, column 0, even when a previous frame is incomplete.
- R9: While the final line is being emitted, in_valid is ignored, together with any in_sof, depth and color it accompanies.
- R10: Idle cycles (in_valid low) during a frame pause the stream. The block produces exactly one output pixel per input pixel, and the results are unchanged by the idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_depth | input | DW | Pixel depth |
| in_color | input | CW | Pixel color |
| tab_we | input | 1 | Table write strobe |
| tab_addr | input | 2*GB | Table write index |
| tab_data | input | FW | Table intensity factor |
| out_valid | output | 1 | Shaded pixel present |
| out_sof | output | 1 | First shaded pixel of a frame |
| out_eol | output | 1 | Last shaded pixel of a line |
| out_color | output | CW | Shaded color |

## Verification
Each test drives a frame through the shader and compares every output pixel with values computed from the requirements.

A flat depth field exercises only table entry 0. A horizontal ramp moves only the gx field, and a steep vertical ramp saturates only gy, so together they show whether the two fields land in the right index bits and clamp correctly. Small-range pseudo-random depths cover unsaturated values in both fields, and large-range pseudo-random depths mostly exercise saturation.

Further patterns check the stream-control rules:
- Gapped input shows that stalls do not disturb the results.
- Junk pixels with start markers during the final-line phase show that input is ignored there.
- A truncated frame followed by a new start marker checks the restart.
- Rewriting the table checks that the new factors take effect.

// File: rtl/grad_shader.sv
module grad_shader #(
  parameter int W  = 256,
  parameter int H  = 256,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int FW = 8,
  parameter int GB = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic                in_eol,
  input  logic [DW-1:0]       in_depth,
  input  logic [CW-1:0]       in_color,
  input  logic                tab_we,
  input  logic [2*GB-1:0]     tab_addr,
  input  logic [FW-1:0]       tab_data,
  output logic                out_valid,
  output logic                out_sof,
  output logic                out_eol,
  output logic [CW-1:0]       out_color
);
  localparam int AW   = (W > 1) ? $clog2(W) : 1;
  localparam int RW   = $clog2(H + 1);
  localparam int IW   = 2 * GB;
  localparam int TN   = 1 << IW;
  localparam int GMAX = (1 << (GB - 1)) - 1;

  logic [DW-1:0] dmem [3][W];
  logic [CW-1:0] cmem [3][W];
  logic [FW-1:0] tab  [TN];

  logic [AW-1:0] col;
  logic [RW-1:0] row;
  logic [1:0]    wb;
  logic          flush;

  logic          accept, restart, step, produce;
  logic [AW-1:0] e_col, cm1, cp1;
  logic [RW-1:0] e_row;
  logic [1:0]    e_wb, pb, qb, nb;

  assign accept  = in_valid & ~flush;
  assign restart = accept & in_sof;
  assign step    = flush | accept;
  assign e_col   = restart ? '0 : col;
  assign e_row   = restart ? '0 : row;
  assign e_wb    = restart ? 2'd0 : wb;
  assign cm1     = e_col - 1'b1;
  assign cp1     = e_col + 1'b1;
  assign pb      = (e_wb == 2'd0) ? 2'd2 : e_wb - 2'd1;
  assign qb      = (e_wb == 2'd2) ? 2'd0 : e_wb + 2'd1;
  assign nb      = qb;
  assign produce = step && (e_row != '0);

  logic [DW-1:0] cd, ld, rd, ad, bd;
  logic [CW-1:0] cc;
  assign cd = dmem[pb][e_col];
  assign cc = cmem[pb][e_col];
  assign ld = (e_col == '0)          ? cd : dmem[pb][cm1];
  assign rd = (e_col == AW'(W - 1))  ? cd : dmem[pb][cp1];
  assign ad = (e_row == RW'(1))      ? cd : dmem[qb][e_col];
  assign bd = flush                  ? cd : in_depth;

  function automatic logic [GB-1:0] clampg(input logic signed [DW:0] v);
    if (v > GMAX)            return GB'(GMAX);
    else if (v < -GMAX - 1)  return GB'(-GMAX - 1);
    else                     return GB'(v);
  endfunction

  logic signed [DW:0] gx, gy;
  assign gx = $signed({1'b0, rd}) - $signed({1'b0, ld});
  assign gy = $signed({1'b0, bd}) - $signed({1'b0, ad});

  always_ff @(posedge clk) begin
    if (accept) begin
      dmem[e_wb][e_col] <= in_depth;
      cmem[e_wb][e_col] <= in_color;
    end
  end

  always_ff @(posedge clk) begin
    if (tab_we) tab[tab_addr] <= tab_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col   <= '0;
      row   <= '0;
      wb    <= 2'd0;
      flush <= 1'b0;
    end else if (flush) begin
      if (col == AW'(W - 1)) begin
        flush <= 1'b0;
        col   <= '0;
        row   <= '0;
        wb    <= 2'd0;
      end else begin
        col <= col + 1'b1;
      end
    end else if (accept) begin
      if (in_eol) begin
        col <= '0;
        wb  <= nb;
        row <= e_row + 1'b1;
        if (e_row == RW'(H - 1)) flush <= 1'b1;
      end else begin
        col <= e_col + 1'b1;
        row <= e_row;
        wb  <= e_wb;
      end
    end
  end

  logic          s1_v, s1_sof, s1_eol;
  logic [IW-1:0] s1_idx;
  logic [CW-1:0] s1_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sof <= 1'b0;
      s1_eol <= 1'b0;
      s1_idx <= '0;
      s1_c   <= '0;
    end else begin
      s1_v   <= produce;
      s1_sof <= produce && (e_row == RW'(1)) && (e_col == '0);
      s1_eol <= produce && (e_col == AW'(W - 1));
      s1_idx <= {clampg(gx), clampg(gy)};
      s1_c   <= cc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_color <= '0;
    end else begin
      out_valid <= s1_v;
      out_sof   <= s1_sof;
      out_eol   <= s1_eol;
      out_color <= CW'(({{FW{1'b0}}, s1_c} * {{CW{1'b0}}, tab[s1_idx]}) >> FW);
    end
  end
endmodule

module grad_shader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_eol,
  input logic flush,
  input logic out_valid,
  input logic out_sof,
  input logic out_eol
);
  assert_sof_marks_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  assert_eol_marks_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);
  assert_output_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid || flush, 2));
  assert_drain_after_line_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> $past(in_valid && in_eol));
  assert_drain_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ##2 out_valid);
endmodule

bind grad_shader grad_shader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eol(in_eol), .flush(flush),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/grad_shader_bench.sv
module grad_shader_bench;
  localparam int W = 8;
  localparam int H = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0, in_sof = 0, in_eol = 0;
  logic [7:0] in_depth = 0, in_color = 0;
  logic       tab_we = 0;
  logic [5:0] tab_addr = 0;
  logic [7:0] tab_data = 0;
  logic       out_valid, out_sof, out_eol;
  logic [7:0] out_color;

  grad_shader #(.W(W), .H(H)) u_grad_shader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_depth(in_depth), .in_color(in_color), .tab_we(tab_we), .tab_addr(tab_addr),
    .tab_data(tab_data), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_color(out_color)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n = 0;
  bit cap_en = 0;
  int dep [H][W];
  int colr[H][W];
  int drv [H][W];
  int tabm[64];
  int cap_c[64], cap_s[64], cap_e[64], cap_t[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cap_en && out_valid && n < 64) begin
      cap_c[n] = out_color; cap_s[n] = out_sof; cap_e[n] = out_eol; cap_t[n] = cyc;
      n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp3(input int v);
    if (v > 3) return 3;
    if (v < -4) return -4;
    return v;
  endfunction

  function automatic int expect_px(input int r, input int c);
    int cd = dep[r][c];
    int l  = (c == 0)     ? cd : dep[r][c-1];
    int rt = (c == W - 1) ? cd : dep[r][c+1];
    int a  = (r == 0)     ? cd : dep[r-1][c];
    int b  = (r == H - 1) ? cd : dep[r+1][c];
    int idx = ((clamp3(rt - l) & 7) << 3) | (clamp3(b - a) & 7);
    return (colr[r][c] * tabm[idx]) >> 8;
  endfunction

  task automatic load_tab(input int kind);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tabm[i] = (kind == 0) ? ((i * 4 + 3) & 255) : (255 - i * 3);
      tab_we = 1; tab_addr = 6'(i); tab_data = 8'(tabm[i]);
    end
    @(negedge clk);
    tab_we = 0;
  endtask

  task automatic run_frame(input int mode, input bit gaps, input bit junk, input string nm);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (mode)
          0: dep[r][c] = 50;
          1: dep[r][c] = c + 10;
          2: dep[r][c] = (r * 53 + c * 29 + 17) & 255;
          3: dep[r][c] = r * 60 + c;
          default: dep[r][c] = (r * 3 + c * 5) % 7;
        endcase
        colr[r][c] = (r * 31 + c * 17 + mode * 11 + 5) & 255;
      end
    n = 0; cap_en = 1;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps && ((r * W + c) % 3 == 1)) begin
          @(negedge clk); in_valid = 0;
        end
        @(negedge clk);
        in_valid = 1; in_sof = (r == 0 && c == 0); in_eol = (c == W - 1);
        in_depth = 8'(dep[r][c]); in_color = 8'(colr[r][c]); drv[r][c] = cyc;
      end
    @(negedge clk);
    if (junk)
      for (int j = 0; j < W - 1; j++) begin
        in_valid = 1; in_sof = 1; in_eol = (j == 2);
        in_depth = 8'(j * 77 + 9); in_color = 8'(j * 41);
        @(negedge clk);
      end
    in_valid = 0; in_sof = 0; in_eol = 0;
    repeat (W + 8) @(negedge clk);
    cap_en = 0;
    chk(junk ? "R9" : "R10", {nm, " pixel count"}, n, H * W);
    for (int k = 0; k < H * W && k < n; k++) begin
      int r = k / W;
      int c = k % W;
      bit border = (r == 0 || r == H - 1 || c == 0 || c == W - 1);
      chk(border ? "R4" : "R2/R3", $sformatf("%s color r%0d c%0d", nm, r, c),
          cap_c[k], expect_px(r, c));
      chk("R6", $sformatf("%s sof r%0d c%0d", nm, r, c), cap_s[k], int'(r == 0 && c == 0));
      chk("R6", $sformatf("%s eol r%0d c%0d", nm, r, c), cap_e[k], int'(c == W - 1));
      chk("R5", $sformatf("%s timing r%0d c%0d", nm, r, c), cap_t[k],
          (r < H - 1) ? drv[r+1][c] + 2 : drv[H-1][W-1] + 3 + c);
    end
  endtask

  task automatic t_reset;
    int seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk("R1", "no output after reset", seen, 0);
  endtask

  task automatic t_flat;        run_frame(0, 0, 0, "flat");       endtask
  task automatic t_hramp;       run_frame(1, 0, 0, "hramp");      endtask
  task automatic t_vsteep;      run_frame(3, 0, 0, "vsteep R2");  endtask
  task automatic t_small_gaps;  run_frame(4, 1, 0, "gaps R10");   endtask
  task automatic t_junk_drain;  run_frame(2, 0, 1, "junk R9");    endtask

  task automatic t_table_rewrite;
    load_tab(1);
    run_frame(4, 0, 0, "newtab R7");
  endtask

  task automatic t_restart;
    for (int k = 0; k < W + W / 2; k++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (k == 0); in_eol = ((k % W) == W - 1);
      in_depth = 8'(k * 13); in_color = 8'(k);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eol = 0;
    repeat (4) @(negedge clk);
    run_frame(2, 0, 0, "restart R8");
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    load_tab(0);
    t_flat();
    t_hramp();
    t_vsteep();
    t_small_gaps();
    t_junk_drain();
    t_restart();
    t_table_rewrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule